// File: doc/BRIEF.md
# Serial Bus Gap and Arbitration Timer

This block keeps time for a shared serial backplane bus. Every duration is counted in base-rate bit times. Each bit time is marked by a single-cycle enable, `tick_i`, taken from a 49.152 MHz base clock. While the bus stays quiet, an idle counter measures how long it has been silent. That count is compared against three nested thresholds, which classify the silence as an acknowledge gap, a subaction gap or an arbitration reset gap. Each class has a single-cycle detection pulse and a level flag. The flag holds until traffic returns.

A second, independent timer drives the arbitration bit cadence while arbitration is requested. Each arbitration bit spans eight base ticks. The block gives a strobe on the first tick of every bit and a sample strobe on tick 5 inside it. The surrounding bus logic uses these strobes to drive and sample its arbitration bits. The block contains no line drivers, no packet framing and no arbitration decision.

Top module: `sbus_gap_arb_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the idle count and the arbitration position to zero. After that edge, every pulse, flag and strobe output is 0.
- R2: The idle count advances by one at each clock edge where `tick_i` and `bus_idle_i` are both 1. It holds on idle cycles without a tick. At any edge where `bus_idle_i` is 0 it clears to zero, tick or not, so all gap flags read 0 in the following cycle.
- R3: The idle count saturates at the arbitration reset threshold (20 ticks) and never wraps. Further idle ticks therefore leave every flag high and produce no further gap pulse.
- R4: `ack_gap_pulse_o` is 1 for exactly one clock cycle, in the cycle after the edge that takes the 8th consecutive idle tick. `ack_gap_o` is 1 from that cycle until bus activity resumes.
- R5: `sub_gap_pulse_o` is 1 for exactly one clock cycle after the 14th consecutive idle tick. `sub_gap_o` is then 1 until bus activity resumes.
- R6: `rst_gap_pulse_o` is 1 for exactly one clock cycle after the 20th consecutive idle tick. `rst_gap_o` is then 1 until bus activity resumes.
- R7: The gap flags nest: `rst_gap_o` implies `sub_gap_o`, and `sub_gap_o` implies `ack_gap_o`. At most one gap pulse is high in any cycle.
- R8: The arbitration position advances only on ticks while `arb_req_i` is 1. While `arb_req_i` is 0 the position is held at zero and both arbitration strobes are 0 in the next cycle. A rising request therefore always starts at tick 0.
- R9: `arb_bound_o` is 1 for one clock cycle after every tick that falls on position 0 of an eight-tick arbitration bit. This includes the first tick after the request rises.
- R10: `arb_sample_o` is 1 for one clock cycle after every tick that falls on position 5 of an arbitration bit. It never coincides with `arb_bound_o`.
- R11: Gap timing and arbitration timing run independently. A gap pulse and an arbitration strobe produced by the same tick are both output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One base-rate bit time elapsed (single-cycle enable) |
| bus_idle_i | input | 1 | Bus currently idle |
| arb_req_i | input | 1 | Arbitration in progress, run the bit cadence |
| ack_gap_pulse_o | output | 1 | Acknowledge gap reached (one cycle) |
| sub_gap_pulse_o | output | 1 | Subaction gap reached (one cycle) |
| rst_gap_pulse_o | output | 1 | Arbitration reset gap reached (one cycle) |
| ack_gap_o | output | 1 | Idle for at least the acknowledge gap |
| sub_gap_o | output | 1 | Idle for at least the subaction gap |
| rst_gap_o | output | 1 | Idle for at least the arbitration reset gap |
| arb_bound_o | output | 1 | Arbitration bit boundary strobe |
| arb_sample_o | output | 1 | Arbitration sample strobe |

## Verification
Two functions can fire in the same cycle: a gap pulse from the idle counter and an arbitration strobe from the bit timer. Both are driven by the same base tick. To provoke the overlap, the bench starts arbitration two ticks into an idle run. The eighth idle tick then lands on position 5 of the arbitration bit. The bench requires the acknowledge pulse and the sample strobe to be high together in the one sampled cycle, with the boundary strobe low. It also checks that the nested gap classification and the eight-tick cadence both continue undisturbed after that cycle.

// File: rtl/sbus_timer_pkg.sv
package sbus_timer_pkg;

  localparam int unsigned GAP_KINDS = 3;

  typedef enum logic [1:0] {
    GAP_ACK = 2'd0,
    GAP_SUB = 2'd1,
    GAP_RST = 2'd2
  } gap_kind_e;

  // Saturating increment of the idle measure.
  function automatic int unsigned idle_step(int unsigned cur, int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

  // True when the next idle tick makes the count equal to the threshold.
  function automatic logic crosses(int unsigned cur, int unsigned thresh);
    return (cur + 1) == thresh;
  endfunction

  // Position inside an arbitration bit after one more tick.
  function automatic int unsigned arb_advance(int unsigned pos, int unsigned len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/sbus_idle_counter.sv
module sbus_idle_counter
  import sbus_timer_pkg::*;
#(
  parameter int unsigned LIMIT = 20,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          idle_i,
  output logic [CW-1:0] count_o,
  output logic          step_o
);

  logic [CW-1:0] count_q;

  // Named event: one idle tick is accounted this cycle.
  assign step_o  = tick_i && idle_i && (32'(count_q) < LIMIT);
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!idle_i) begin
      count_q <= '0;
    end else if (step_o) begin
      count_q <= CW'(idle_step(32'(count_q), LIMIT));
    end
  end

  p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    32'(count_q) <= LIMIT);

  p_busy_clears_r2: assert property (@(posedge clk) disable iff (rst)
    !idle_i |=> count_q == '0);

  p_step_adds_one_r2: assert property (@(posedge clk) disable iff (rst)
    step_o |=> count_q == $past(count_q) + CW'(1));

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !tick_i) |=> $stable(count_q));

endmodule

// File: rtl/sbus_gap_stage.sv
module sbus_gap_stage
  import sbus_timer_pkg::*;
#(
  parameter int unsigned THRESH = 8,
  parameter int unsigned CW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          idle_i,
  input  logic [CW-1:0] count_i,
  output logic          pulse_o,
  output logic          level_o
);

  logic hit;
  logic pulse_q;

  // Named event: this tick completes the threshold.
  assign hit     = tick_i && idle_i && crosses(32'(count_i), THRESH);
  assign level_o = 32'(count_i) >= THRESH;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= hit;
  end

  // Covers R4, R5 and R6 per instance.
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  p_pulse_with_level_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> level_o);

  p_level_needs_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(level_o) |-> pulse_q);

endmodule

// File: rtl/sbus_gap_detect.sv
module sbus_gap_detect
  import sbus_timer_pkg::*;
#(
  parameter int unsigned ACK_GAP = 8,
  parameter int unsigned SUB_GAP = 14,
  parameter int unsigned RST_GAP = 20,
  localparam int unsigned CW = $clog2(RST_GAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 idle_i,
  output logic [GAP_KINDS-1:0] pulse_o,
  output logic [GAP_KINDS-1:0] level_o
);

  localparam int unsigned THR [GAP_KINDS] = '{ACK_GAP, SUB_GAP, RST_GAP};

  logic [CW-1:0] idle_count;
  logic          idle_step_ev;

  sbus_idle_counter #(.LIMIT(RST_GAP)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .idle_i  (idle_i),
    .count_o (idle_count),
    .step_o  (idle_step_ev)
  );

  for (genvar g = 0; g < GAP_KINDS; g++) begin : g_stage
    sbus_gap_stage #(.THRESH(THR[g]), .CW(CW)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tick_i),
      .idle_i  (idle_i),
      .count_i (idle_count),
      .pulse_o (pulse_o[g]),
      .level_o (level_o[g])
    );
  end

  p_nest_rst_sub_r7: assert property (@(posedge clk) disable iff (rst)
    level_o[GAP_RST] |-> level_o[GAP_SUB]);

  p_nest_sub_ack_r7: assert property (@(posedge clk) disable iff (rst)
    level_o[GAP_SUB] |-> level_o[GAP_ACK]);

  p_one_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse_o));

  p_pulse_follows_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pulse_o != '0) |-> $past(idle_step_ev));

endmodule

// File: rtl/sbus_arb_bit_timer.sv
module sbus_arb_bit_timer
  import sbus_timer_pkg::*;
#(
  parameter int unsigned BIT_LEN   = 8,
  parameter int unsigned SAMPLE_AT = 5,
  localparam int unsigned PW = $clog2(BIT_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic req_i,
  output logic bound_o,
  output logic sample_o
);

  logic [PW-1:0] pos_q;
  logic          advance;
  logic          bound_q;
  logic          sample_q;

  assign advance  = tick_i && req_i;
  assign bound_o  = bound_q;
  assign sample_o = sample_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i) begin
      pos_q    <= '0;
      bound_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      bound_q  <= tick_i && (pos_q == '0);
      sample_q <= tick_i && (32'(pos_q) == SAMPLE_AT);
      if (tick_i) pos_q <= PW'(arb_advance(32'(pos_q), BIT_LEN));
    end
  end

  p_quiet_without_req_r8: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!bound_q && !sample_q && pos_q == '0));

  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (req_i && !tick_i) |=> $stable(pos_q));

  p_bound_then_pos1_r9: assert property (@(posedge clk) disable iff (rst)
    bound_q |-> pos_q == PW'(1 % BIT_LEN));

  p_sample_then_next_r10: assert property (@(posedge clk) disable iff (rst)
    sample_q |-> pos_q == PW'((SAMPLE_AT + 1) % BIT_LEN));

  p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(bound_q && sample_q));

  p_strobe_needs_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (bound_q || sample_q) |-> $past(advance));

endmodule

// File: rtl/sbus_gap_arb_timer.sv
module sbus_gap_arb_timer
  import sbus_timer_pkg::*;
#(
  parameter int unsigned ACK_GAP       = 8,
  parameter int unsigned SUB_GAP       = 14,
  parameter int unsigned RST_GAP       = 20,
  parameter int unsigned ARB_BIT_LEN   = 8,
  parameter int unsigned ARB_SAMPLE_AT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic bus_idle_i,
  input  logic arb_req_i,
  output logic ack_gap_pulse_o,
  output logic sub_gap_pulse_o,
  output logic rst_gap_pulse_o,
  output logic ack_gap_o,
  output logic sub_gap_o,
  output logic rst_gap_o,
  output logic arb_bound_o,
  output logic arb_sample_o
);

  logic [GAP_KINDS-1:0] gap_pulse;
  logic [GAP_KINDS-1:0] gap_level;

  sbus_gap_detect #(
    .ACK_GAP (ACK_GAP),
    .SUB_GAP (SUB_GAP),
    .RST_GAP (RST_GAP)
  ) u_gap (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .idle_i  (bus_idle_i),
    .pulse_o (gap_pulse),
    .level_o (gap_level)
  );

  sbus_arb_bit_timer #(
    .BIT_LEN   (ARB_BIT_LEN),
    .SAMPLE_AT (ARB_SAMPLE_AT)
  ) u_arb (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .req_i    (arb_req_i),
    .bound_o  (arb_bound_o),
    .sample_o (arb_sample_o)
  );

  assign ack_gap_pulse_o = gap_pulse[GAP_ACK];
  assign sub_gap_pulse_o = gap_pulse[GAP_SUB];
  assign rst_gap_pulse_o = gap_pulse[GAP_RST];
  assign ack_gap_o       = gap_level[GAP_ACK];
  assign sub_gap_o       = gap_level[GAP_SUB];
  assign rst_gap_o       = gap_level[GAP_RST];

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (gap_pulse == '0 && gap_level == '0 && !arb_bound_o && !arb_sample_o));

endmodule

// File: tb/sbus_gap_arb_timer_tb.sv
module sbus_gap_arb_timer_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic bus_idle_i = 1'b0;
  logic arb_req_i = 1'b0;
  logic ack_gap_pulse_o, sub_gap_pulse_o, rst_gap_pulse_o;
  logic ack_gap_o, sub_gap_o, rst_gap_o;
  logic arb_bound_o, arb_sample_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sbus_gap_arb_timer u_dut (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick_i),
    .bus_idle_i      (bus_idle_i),
    .arb_req_i       (arb_req_i),
    .ack_gap_pulse_o (ack_gap_pulse_o),
    .sub_gap_pulse_o (sub_gap_pulse_o),
    .rst_gap_pulse_o (rst_gap_pulse_o),
    .ack_gap_o       (ack_gap_o),
    .sub_gap_o       (sub_gap_o),
    .rst_gap_o       (rst_gap_o),
    .arb_bound_o     (arb_bound_o),
    .arb_sample_o    (arb_sample_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // One tick on its own clock, sampled after the capturing edge.
  task automatic give_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic quiet_cycle();
    @(negedge clk);
  endtask

  task automatic make_busy();
    @(negedge clk) bus_idle_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_eq("R1", "gap flags after reset", {ack_gap_o, sub_gap_o, rst_gap_o}, 0);
    chk_eq("R1", "pulses after reset", {ack_gap_pulse_o, sub_gap_pulse_o, rst_gap_pulse_o}, 0);
    chk_eq("R1", "arb strobes after reset", {arb_bound_o, arb_sample_o}, 0);
  endtask

  // Idle run of n ticks; every tick checked against the gap thresholds.
  task automatic t_idle_run(input int n);
    make_busy();
    bus_idle_i = 1'b1;
    for (int k = 1; k <= n; k++) begin
      give_tick();
      chk_eq("R4", $sformatf("ack pulse tick %0d of %0d", k, n), ack_gap_pulse_o, k == 8);
      chk_eq("R5", $sformatf("sub pulse tick %0d of %0d", k, n), sub_gap_pulse_o, k == 14);
      chk_eq("R6", $sformatf("rst pulse tick %0d of %0d", k, n), rst_gap_pulse_o, k == 20);
      chk_eq("R7", $sformatf("flags tick %0d of %0d", k, n),
             {ack_gap_o, sub_gap_o, rst_gap_o}, {k >= 8, k >= 14, k >= 20});
      quiet_cycle();
      chk_eq("R2", "pulses last one cycle, count holds without tick",
             {ack_gap_pulse_o, sub_gap_pulse_o, rst_gap_pulse_o, ack_gap_o, sub_gap_o, rst_gap_o},
             {3'b000, k >= 8, k >= 14, k >= 20});
    end
    if (n > 20) chk_eq("R3", "saturated flags stay high", {ack_gap_o, sub_gap_o, rst_gap_o}, 3'b111);
    // Busy cycle with no tick clears the measure.
    @(negedge clk) bus_idle_i = 1'b0;
    @(negedge clk);
    chk_eq("R2", $sformatf("flags cleared after run %0d", n), {ack_gap_o, sub_gap_o, rst_gap_o}, 0);
  endtask

  // Activity inside a run restarts the count from zero.
  task automatic t_interrupted();
    make_busy();
    bus_idle_i = 1'b1;
    for (int k = 0; k < 7; k++) give_tick();
    @(negedge clk) bus_idle_i = 1'b0;
    @(negedge clk) bus_idle_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      give_tick();
      chk_eq("R2", $sformatf("ack pulse after restart tick %0d", k), ack_gap_pulse_o, k == 8);
    end
  endtask

  task automatic t_arb_bits();
    make_busy();
    @(negedge clk) arb_req_i = 1'b1;
    for (int j = 0; j < 24; j++) begin
      give_tick();
      chk_eq("R9", $sformatf("boundary at arb tick %0d", j), arb_bound_o, (j % 8) == 0);
      chk_eq("R10", $sformatf("sample at arb tick %0d", j), arb_sample_o, (j % 8) == 5);
      quiet_cycle();
      chk_eq("R8", "strobes one cycle", {arb_bound_o, arb_sample_o}, 0);
    end
    // Drop mid-bit: strobes stay quiet while ticks continue.
    for (int j = 0; j < 3; j++) give_tick();
    @(negedge clk) arb_req_i = 1'b0;
    for (int j = 0; j < 8; j++) begin
      give_tick();
      chk_eq("R8", "no strobe without request", {arb_bound_o, arb_sample_o}, 0);
    end
    @(negedge clk) arb_req_i = 1'b1;
    for (int j = 0; j < 6; j++) begin
      give_tick();
      chk_eq("R9", $sformatf("restart boundary tick %0d", j), arb_bound_o, j == 0);
      chk_eq("R10", $sformatf("restart sample tick %0d", j), arb_sample_o, j == 5);
    end
    @(negedge clk) arb_req_i = 1'b0;
  endtask

  // Acknowledge pulse and sample strobe from the same tick.
  task automatic t_overlap();
    make_busy();
    bus_idle_i = 1'b1;
    give_tick();
    give_tick();
    @(negedge clk) arb_req_i = 1'b1;
    for (int k = 3; k <= 16; k++) begin
      give_tick();
      chk_eq("R11", $sformatf("ack pulse idle tick %0d", k), ack_gap_pulse_o, k == 8);
      chk_eq("R11", $sformatf("sample idle tick %0d", k), arb_sample_o, ((k - 3) % 8) == 5);
      chk_eq("R11", $sformatf("boundary idle tick %0d", k), arb_bound_o, ((k - 3) % 8) == 0);
    end
  endtask

  task automatic t_reset_mid();
    for (int k = 0; k < 6; k++) give_tick();
    chk_eq("R1", "flags high before reset", {ack_gap_o, sub_gap_o, rst_gap_o}, 3'b111);
    @(negedge clk) begin rst = 1'b1; tick_i = 1'b1; end
    @(negedge clk) begin rst = 1'b0; tick_i = 1'b0; end
    chk_eq("R1", "all outputs after mid reset",
           {ack_gap_pulse_o, sub_gap_pulse_o, rst_gap_pulse_o, ack_gap_o, sub_gap_o, rst_gap_o,
            arb_bound_o, arb_sample_o}, 0);
    give_tick();
    chk_eq("R1", "arb restarts at tick 0 after reset", arb_bound_o, 1);
    arb_req_i = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_idle_run(7);
    t_idle_run(8);
    t_idle_run(13);
    t_idle_run(14);
    t_idle_run(19);
    t_idle_run(20);
    t_idle_run(30);
    t_interrupted();
    t_arb_bits();
    t_overlap();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule